// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Thresholds

This block is a single-clock FIFO controller wrapped around a simple dual-port RAM. A write pointer counter and a read pointer counter produce the RAM addresses. Each pointer carries one extra wrap bit, so the stored word count is their difference. The four status outputs come from that count: empty, full, almost-empty and almost-full.

Width and depth are parameters chosen from the usual RAM organisations (18 bits by 256 words down to 1 bit by 4096 words). The two "almost" thresholds are runtime input ports, so software or a neighbouring block can move them while the FIFO is in use. A write into a full FIFO is dropped. A read from an empty FIFO is dropped. Read data is registered and appears one clock after the read is accepted.

Top module: `prog_fifo`

## Requirements
- R1: While `rst_ni` is low and after it rises, with no traffic, `empty_o`=1, `aempty_o`=1, `full_o`=0, and `afull_o`=0 (for any `af_thr_i` above zero).
- R2: Words leave in the order they were written. The word for a read accepted at a clock edge is on `rd_data_o` just after that edge.
- R3: A write while `full_o`=1 is ignored. `full_o` stays high, no pointer moves, and the dropped word is never read out.
- R4: A read while `empty_o`=1 is ignored. `empty_o` stays high and `rd_data_o` keeps its previous value.
- R5: An accepted read and an accepted write in the same cycle leave the word count unchanged, so all four flags hold.
- R6: `empty_o`=1 exactly when the count is 0. `full_o`=1 exactly when the count equals DEPTH.
- R7: `aempty_o`=1 exactly when the count is less than or equal to `ae_thr_i`.
- R8: `afull_o`=1 exactly when the count is greater than or equal to `af_thr_i`.
- R9: A change on `ae_thr_i` or `af_thr_i` affects the almost flags in the same cycle, without a clock edge.
- R10: Pointers wrap past DEPTH with ordering and flags intact across many full and partial cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for reads and writes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read data |
| ae_thr_i | input | CNT_W | Almost-empty threshold (count at or below it) |
| af_thr_i | input | CNT_W | Almost-full threshold (count at or above it) |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| aempty_o | output | 1 | Count at or below `ae_thr_i` |
| afull_o | output | 1 | Count at or above `af_thr_i` |

## Verification
Some properties are checked by assertions on every cycle. Empty and full are never both high. The count never exceeds DEPTH. A blocked write at full or a blocked read at empty leaves the flags and pointers alone. A simultaneous accepted read and write keeps the count steady. Data ordering, the exact threshold comparisons, runtime threshold changes and pointer wrap-around are shown only by the bench's directed scenarios, which check them against a queue model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] ptr_o
);
  // extra MSB is the wrap bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (inc_i) ptr_o <= ptr_o + CNT_W'(1);
  end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] wr_ptr_i,
  input  logic [CNT_W-1:0] rd_ptr_i,
  input  logic [CNT_W-1:0] ae_thr_i,
  input  logic [CNT_W-1:0] af_thr_i,
  output logic [CNT_W-1:0] fill_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             aempty_o,
  output logic             afull_o
);
  always_comb begin
    fill_o   = wr_ptr_i - rd_ptr_i;
    empty_o  = (fill_o == '0);
    full_o   = (fill_o == CNT_W'(DEPTH));
    aempty_o = (fill_o <= ae_thr_i);
    afull_o  = (fill_o >= af_thr_i);
  end

  always_comb begin
    a_excl_r6: assert (!(empty_o && full_o));
    a_range_r6: assert (fill_o <= CNT_W'(DEPTH));
  end
endmodule

// File: rtl/prog_fifo.sv
module prog_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0]  ae_thr_i,
  input  logic [CNT_W-1:0]  af_thr_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              aempty_o,
  output logic              afull_o
);
  logic [CNT_W-1:0] wr_ptr, rd_ptr, fill;
  logic             push, pop;
  fifo_op_e         op;

  assign push = wr_en_i && !full_o;
  assign pop  = rd_en_i && !empty_o;
  assign op   = fifo_op_e'({pop, push});

  sfifo_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(push), .ptr_o(wr_ptr)
  );

  sfifo_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pop), .ptr_o(rd_ptr)
  );

  sfifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(push), .waddr_i(wr_ptr[ADDR_W-1:0]), .wdata_i(wr_data_i),
    .re_i(pop),  .raddr_i(rd_ptr[ADDR_W-1:0]), .rdata_o(rd_data_o)
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .ae_thr_i(ae_thr_i), .af_thr_i(af_thr_i),
    .fill_o(fill), .empty_o(empty_o), .full_o(full_o),
    .aempty_o(aempty_o), .afull_o(afull_o)
  );

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> (full_o && $stable(wr_ptr)));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> (empty_o && $stable(rd_ptr) && $stable(rd_data_o)));

  p_count_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BOTH) |=> $stable(fill));

  p_leave_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_en_i) |=> !empty_o);

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (empty_o && aempty_o && !full_o));
endmodule

// File: tb/prog_fifo_bench.sv
module prog_fifo_bench;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 256;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  ae_thr = CNT_W'(4), af_thr = CNT_W'(252);
  logic              empty, full, aempty, afull;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] last_rd = '0;
  int seq = 0;

  always #5 clk = ~clk;

  prog_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_prog_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data),
    .ae_thr_i(ae_thr), .af_thr_i(af_thr),
    .empty_o(empty), .full_o(full), .aempty_o(aempty), .afull_o(afull)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags();
    int n = q.size();
    return {n == 0, n == DEPTH, n <= int'(ae_thr), n >= int'(af_thr)};
  endfunction

  task automatic check_flags(input string req);
    logic [3:0] act = {empty, full, aempty, afull};
    check(act == exp_flags(), req, act, exp_flags());
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic step(input bit wr, input bit rd, input logic [DATA_W-1:0] d,
                      input string req, input bit chk_flags);
    bit wr_ok, rd_ok;
    logic [DATA_W-1:0] exp_d;
    wr_en = wr; rd_en = rd; wr_data = d;
    wr_ok = wr && q.size() < DEPTH;
    rd_ok = rd && q.size() > 0;
    exp_d = last_rd;
    if (rd_ok) exp_d = q.pop_front();
    if (wr_ok) q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (rd_ok || rd) check(rd_data == exp_d, {req, " rd_data"}, rd_data, exp_d);
    last_rd = exp_d;
    if (chk_flags) check_flags(req);
  endtask

  function automatic logic [DATA_W-1:0] pat();
    seq++;
    return DATA_W'(seq * 37 + 5) ^ DATA_W'(seq << 9);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check({empty, full, aempty, afull} == 4'b1010, "R1 in reset", {empty, full, aempty, afull}, 4'b1010);
    rst_ni = 1'b1;
    @(negedge clk);
    check({empty, full, aempty, afull} == 4'b1010, "R1 after reset", {empty, full, aempty, afull}, 4'b1010);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) step(1, 0, pat(), "R6 R7 R8 fill", 1);
    check(full == 1'b1, "R6 full at DEPTH", full, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 1, '0, "R2 R7 R8 drain", 1);
    check(empty == 1'b1, "R6 empty after drain", empty, 1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) step(1, 0, pat(), "R3 prefill", 0);
    for (int i = 0; i < 3; i++) step(1, 0, '1, "R3 write at full", 1);
    step(1, 1, '1, "R3 read+write at full", 1);
    check(full == 1'b0, "R3 full dropped after read", full, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 1, '0, "R3 drain no dropped word", 0);
    check_flags("R3 empty after drain");
  endtask

  task automatic t_underflow();
    for (int i = 0; i < 3; i++) step(0, 1, '0, "R4 read at empty", 1);
    check(rd_data == last_rd, "R4 rd_data held", rd_data, last_rd);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 10; i++) step(1, 0, pat(), "R5 prefill", 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 1, pat(), "R5 simultaneous", 1);
      check(q.size() == 10, "R5 count kept", q.size(), 10);
    end
  endtask

  task automatic t_thresholds();
    // FIFO holds 10 here
    ae_thr = CNT_W'(10); #1;
    check(aempty == 1'b1, "R7 R9 count==ae_thr", aempty, 1);
    ae_thr = CNT_W'(9); #1;
    check(aempty == 1'b0, "R7 R9 count>ae_thr", aempty, 0);
    af_thr = CNT_W'(10); #1;
    check(afull == 1'b1, "R8 R9 count==af_thr", afull, 1);
    af_thr = CNT_W'(11); #1;
    check(afull == 1'b0, "R8 R9 count<af_thr", afull, 0);
    step(1, 0, pat(), "R8 reach af_thr", 1);
    check(afull == 1'b1, "R8 afull at 11", afull, 1);
    ae_thr = CNT_W'(4); af_thr = CNT_W'(252);
    @(negedge clk);
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 150; i++) step(1, (i % 3) == 0, pat(), "R10 mixed push", 1);
      for (int i = 0; i < 120; i++) step((i % 4) == 0, 1, pat(), "R10 mixed pop", 1);
    end
    while (q.size() > 0) step(0, 1, '0, "R10 final drain", 1);
    check(empty == 1'b1, "R10 empty at end", empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_drain();
    t_overflow();
    t_underflow();
    t_simul();
    t_thresholds();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule